// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper

This block decodes the cartridge half of a 13-bit console address bus (the half where bit 12 is high) and maps a 16K ROM and a 2K RAM into that 4K space. The lower 2K of the space is a switchable window. It shows one of seven 2K ROM banks, or 1K of RAM that has a write half and a read half. Above the window sits a 256-byte RAM page, also split into a write half and a read half, which can show any one of four pages. The top 1.5K always shows the end of the ROM. A read of a write-only half returns all ones and also stores all ones into the addressed cell.

Bank state changes when the CPU touches one of twelve trigger addresses near the top of the space. A read or a write triggers equally. The ROM sits outside the block: the block drives a 14-bit ROM index and samples the byte returned in the same cycle. The 2K RAM is held inside the block. Every strobe is sampled on a rising clock edge, and read data appears registered after that edge. A strobe that carries a new bank setting applies it to accesses from the next sampled strobe on.

Top module: `cart_bank_mapper`

## Requirements
- R1: A read or write strobe at 0x1FE0+n (n = 0..6) selects ROM bank n and disables the RAM window. A window read at 0x1000–0x17FF with RAM disabled then returns ROM byte n*2048 + addr[10:0].
- R2: A strobe at 0x1FE7 enables the RAM window. In the window, 0x1000–0x13FF writes and 0x1400–0x17FF reads RAM cell addr[9:0], in RAM cells 0..1023.
- R3: A strobe at 0x1FE8+p (p = 0..3) selects RAM page p. 0x1800–0x18FF writes and 0x1900–0x19FF reads RAM cell 1024 + p*256 + addr[7:0]. The page choice has no effect on the ROM bank.
- R4: A read at 0x1A00–0x1FFF returns ROM byte 0x3800 + addr[10:0]. This includes reads of the trigger addresses.
- R5: A read in a write-only range (0x1800–0x18FF, or 0x1000–0x13FF with the window RAM enabled) returns 0xFF and stores 0xFF into the addressed cell.
- R6: A write to a read half leaves RAM unchanged.
- R7: After reset, ROM bank 0 and RAM page 0 are selected, the window RAM is disabled, and rdata_oe is 0.
- R8: Once enabled, the window RAM stays enabled through page strobes (0x1FE8–0x1FEB). Only a strobe at 0x1FE0–0x1FE6 disables it.
- R9: While addr[12] is 0, rdata_oe stays 0 after a read, and no strobe changes the bank state or RAM.
- R10: A read strobe sampled at edge N raises rdata_oe with valid rdata after edge N. A strobe sampled without rd_en, or with rd_en and wr_en together, leaves rdata_oe low. A RAM write sampled at edge N is visible to a read sampled at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 13 | CPU address |
| wdata | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (has priority over rd_en) |
| rom_addr | output | 14 | Index into the external ROM |
| rom_data | input | 8 | ROM byte at rom_addr, valid in the same cycle |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | High when rdata is being driven for a cartridge read |

## Verification
Two functions share one edge in this block. A trigger access returns a fixed-ROM byte and changes the bank state on the same edge. A read of a write-only half returns 0xFF and corrupts the cell on the same edge. The bench provokes the first case by reading each trigger address and checking the byte against the fixed-ROM formula. The very next window or page read must then reflect the new bank. For the second case, it writes a known value, reads it through the write half (0xFF expected), and reads the same cell back through the read half, where 0xFF must replace the original value.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CPU_AW   = 13;
  localparam int DW       = 8;
  localparam int ROM_AW   = 14;
  localparam int RAM_AW   = 11;
  localparam int WIN_AW   = 11;
  localparam int HALF_AW  = 10;
  localparam int PAGE_AW  = 8;
  localparam int BANK_W   = ROM_AW - WIN_AW;
  localparam int PAGE_SEL_W = RAM_AW - 1 - PAGE_AW;
  localparam int ROM_BYTES = 1 << ROM_AW;
  localparam int WIN_BYTES = 1 << WIN_AW;

  typedef enum logic [2:0] {
    RG_NONE, RG_WIN_ROM, RG_WIN_WR, RG_WIN_RD, RG_PG_WR, RG_PG_RD, RG_FIXED
  } region_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_ROM, SRC_RAM, SRC_ONES} src_e;

  function automatic region_e map_region(input logic [CPU_AW-1:0] a, input logic ram_on);
    if (!a[12]) return RG_NONE;
    if (!a[11]) begin
      if (!ram_on) return RG_WIN_ROM;
      return a[10] ? RG_WIN_RD : RG_WIN_WR;
    end
    if (a[11:8] == 4'h8) return RG_PG_WR;
    if (a[11:8] == 4'h9) return RG_PG_RD;
    return RG_FIXED;
  endfunction

  function automatic logic [ROM_AW-1:0] rom_index(input logic [CPU_AW-1:0] a,
                                                  input logic [BANK_W-1:0] bank,
                                                  input region_e rg);
    if (rg == RG_FIXED)
      return ROM_AW'(ROM_BYTES - WIN_BYTES) + ROM_AW'(a[WIN_AW-1:0]);
    return {bank, a[WIN_AW-1:0]};
  endfunction

  function automatic logic [RAM_AW-1:0] ram_index(input logic [CPU_AW-1:0] a,
                                                  input logic [PAGE_SEL_W-1:0] page,
                                                  input region_e rg);
    if (rg == RG_PG_WR || rg == RG_PG_RD)
      return {1'b1, page, a[PAGE_AW-1:0]};
    return {1'b0, a[HALF_AW-1:0]};
  endfunction

  function automatic logic is_write_half(input region_e rg);
    return (rg == RG_WIN_WR) || (rg == RG_PG_WR);
  endfunction

  function automatic logic is_read_half(input region_e rg);
    return (rg == RG_WIN_RD) || (rg == RG_PG_RD);
  endfunction
endpackage

// File: rtl/cbm_hotspot.sv
module cbm_hotspot
  import cbm_pkg::*;
#(
  parameter logic [CPU_AW-5:0] HOT_ROW = 9'h1FE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  access,
  input  logic [CPU_AW-1:0]     addr,
  output logic [BANK_W-1:0]     rom_bank,
  output logic [PAGE_SEL_W-1:0] ram_page,
  output logic                  win_ram_en,
  output logic                  hot_hit
);
  logic [3:0] nib;
  logic       hit_bank, hit_ram, hit_page;

  assign hot_hit  = access && (addr[CPU_AW-1:4] == HOT_ROW);
  assign nib      = addr[3:0];
  assign hit_bank = hot_hit && (nib < 4'd7);
  assign hit_ram  = hot_hit && (nib == 4'd7);
  assign hit_page = hot_hit && (nib[3:2] == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank   <= '0;
      ram_page   <= '0;
      win_ram_en <= 1'b0;
    end else begin
      if (hit_bank) begin
        rom_bank   <= nib[BANK_W-1:0];
        win_ram_en <= 1'b0;
      end
      if (hit_ram) win_ram_en <= 1'b1;
      if (hit_page) ram_page <= nib[PAGE_SEL_W-1:0];
    end
  end
endmodule

// File: rtl/cbm_ram.sv
module cbm_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdat,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdat
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
    if (re) rdat <= mem[raddr];
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int A_W = CPU_AW,
  parameter int D_W = DW,
  parameter int R_AW = ROM_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] addr,
  input  logic [D_W-1:0] wdata,
  input  logic           rd_en,
  input  logic           wr_en,
  output logic [R_AW-1:0] rom_addr,
  input  logic [D_W-1:0] rom_data,
  output logic [D_W-1:0] rdata,
  output logic           rdata_oe
);
  logic [BANK_W-1:0]     rom_bank;
  logic [PAGE_SEL_W-1:0] ram_page;
  logic                  win_ram_en;
  logic                  hot_hit;
  logic                  cart_access, cart_read, cart_write;
  region_e               region;
  logic [RAM_AW-1:0]     ram_idx;
  logic                  ram_we, ram_re;
  logic [D_W-1:0]        ram_wdat, ram_q;
  src_e                  src_q;
  logic [D_W-1:0]        rom_q;
  logic                  oe_q;

  assign cart_access = (rd_en || wr_en) && addr[12];
  assign cart_write  = wr_en && addr[12];
  assign cart_read   = rd_en && !wr_en && addr[12];

  cbm_hotspot u_hot (
    .clk(clk), .rst_n(rst_n), .access(cart_access), .addr(addr),
    .rom_bank(rom_bank), .ram_page(ram_page), .win_ram_en(win_ram_en),
    .hot_hit(hot_hit)
  );

  assign region   = map_region(addr, win_ram_en);
  assign rom_addr = rom_index(addr, rom_bank, region);
  assign ram_idx  = ram_index(addr, ram_page, region);

  assign ram_we   = (cart_write || cart_read) && is_write_half(region);
  assign ram_wdat = cart_write ? wdata : '1;
  assign ram_re   = cart_read && is_read_half(region);

  cbm_ram #(.AW(RAM_AW), .DW(D_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_idx), .wdat(ram_wdat),
    .re(ram_re), .raddr(ram_idx), .rdat(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      src_q <= SRC_NONE;
      rom_q <= '0;
    end else begin
      oe_q <= cart_read;
      if (!cart_read)                  src_q <= SRC_NONE;
      else if (is_write_half(region))  src_q <= SRC_ONES;
      else if (is_read_half(region))   src_q <= SRC_RAM;
      else                             src_q <= SRC_ROM;
      if (cart_read && (region == RG_WIN_ROM || region == RG_FIXED))
        rom_q <= rom_data;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ROM:  rdata = rom_q;
      SRC_RAM:  rdata = ram_q;
      SRC_ONES: rdata = '1;
      default:  rdata = '0;
    endcase
  end
  assign rdata_oe = oe_q;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  rdata,
  input logic        rdata_oe,
  input logic [2:0]  rom_bank,
  input logic [1:0]  ram_page,
  input logic        win_ram_en
);
  logic acc, rd_only;
  assign acc     = (rd_en || wr_en) && addr[12];
  assign rd_only = rd_en && !wr_en;

  assert_bank_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && addr[12:4] == 9'h1FE && addr[3:0] < 4'd7)
      |=> (rom_bank == $past(addr[2:0]) && !win_ram_en));

  assert_ram_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && addr == 13'h1FE7) |=> win_ram_en);

  assert_page_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && addr[12:2] == 11'h7FA) |=> (ram_page == $past(addr[1:0])
      && rom_bank == $past(rom_bank)));

  assert_page_wport_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && addr[12:8] == 5'h18) |=> (rdata_oe && rdata == 8'hFF));

  assert_win_wport_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && win_ram_en && addr[12:10] == 3'b100) |=> (rdata_oe && rdata == 8'hFF));

  assert_ram_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && addr[12:2] == 11'h7FA) |=> (win_ram_en == $past(win_ram_en)));

  assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr[12]) |=> ($stable(rom_bank) && $stable(ram_page) && $stable(win_ram_en)
      && !rdata_oe));

  assert_oe_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && addr[12]) |=> rdata_oe);

  assert_oe_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_only) |=> !rdata_oe);
endmodule

bind cart_bank_mapper cbm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .rdata(rdata), .rdata_oe(rdata_oe), .rom_bank(rom_bank),
  .ram_page(ram_page), .win_ram_en(win_ram_en)
);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] rom_addr;
  logic [7:0]  rom_data;
  logic [7:0]  rdata;
  logic        rdata_oe;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [13:0] a);
    return 8'(a[7:0] + 8'(a[13:8]) * 8'd37 + 8'd3);
  endfunction

  always_comb rom_data = rom_byte(rom_addr);

  cart_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .rom_addr(rom_addr), .rom_data(rom_data),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [12:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [12:0] a, input logic [7:0] e);
    rd(a);
    check(tag, {rdata_oe, rdata}, {1'b1, e});
  endtask

  task automatic t_reset;
    check("R7 oe after reset", {8'h0, rdata_oe}, 9'h0);
    rd_expect("R7 bank0 at reset", 13'h1123, rom_byte(14'h0123));
    wr(13'h1010, 8'h42);
    rd_expect("R7 window ram off", 13'h1410, rom_byte(14'h0410));
    wr(13'h1820, 8'h99);
    wr(13'h1FE9, 8'h00);
    wr(13'h1FE8, 8'h00);
    rd_expect("R7 page0 at reset", 13'h1920, 8'h99);
  endtask

  task automatic t_rom_banks;
    for (int b = 0; b < 7; b++) begin
      rd_expect("R4 hotspot read fixed rom", 13'(13'h1FE0 + b), rom_byte(14'(14'h3FE0 + b)));
      rd_expect("R1 window bank", 13'(13'h1000 + 13'h155 + b),
                rom_byte(14'(b * 2048 + 16'h155 + b)));
      rd_expect("R1 window bank top", 13'h17FF, rom_byte(14'(b * 2048 + 2047)));
    end
  endtask

  task automatic t_fixed;
    rd_expect("R4 fixed low", 13'h1A00, rom_byte(14'h3A00));
    rd_expect("R4 fixed high", 13'h1FFF, rom_byte(14'h3FFF));
    rd_expect("R4 fixed near hot", 13'h1FEC, rom_byte(14'h3FEC));
  endtask

  task automatic t_window_ram;
    rd_expect("R4 hotspot 1FE7 read", 13'h1FE7, rom_byte(14'h3FE7));
    wr(13'h1005, 8'h5A);
    rd_expect("R2 window write/read", 13'h1405, 8'h5A);
    wr(13'h13FF, 8'hC3);
    rd_expect("R2 window top cell", 13'h17FF, 8'hC3);
    rd_expect("R5 window write-half read", 13'h1005, 8'hFF);
    rd_expect("R5 window cell corrupted", 13'h1405, 8'hFF);
    wr(13'h17FF, 8'h11);
    rd_expect("R6 window read-half write ignored", 13'h17FF, 8'hC3);
  endtask

  task automatic t_persist;
    wr(13'h1FE7, 8'h00);
    wr(13'h1020, 8'h3C);
    rd(13'h1FEA);
    rd_expect("R8 page strobe keeps ram", 13'h1420, 8'h3C);
    wr(13'h1FE2, 8'h00);
    rd_expect("R8 rom strobe clears ram", 13'h1420, rom_byte(14'h1420));
  endtask

  task automatic t_pages;
    for (int p = 0; p < 4; p++) begin
      wr(13'(13'h1FE8 + p), 8'h00);
      wr(13'h1810, 8'(8'h30 + p));
    end
    for (int p = 0; p < 4; p++) begin
      rd(13'(13'h1FE8 + p));
      rd_expect("R3 page readback", 13'h1910, 8'(8'h30 + p));
    end
    rd_expect("R3 rom bank unaffected", 13'h1040, rom_byte(14'h1040));
    wr(13'h1FE7, 8'h00);
    wr(13'h1010, 8'h77);
    wr(13'h1FE8, 8'h00);
    rd_expect("R3 page0 separate from window", 13'h1910, 8'h30);
    rd_expect("R3 window separate from page", 13'h1410, 8'h77);
    wr(13'h1805, 8'hAB);
    wr(13'h1905, 8'hCD);
    rd_expect("R6 page read-half write ignored", 13'h1905, 8'hAB);
    rd_expect("R5 page write-half read", 13'h1805, 8'hFF);
    rd_expect("R5 page cell corrupted", 13'h1905, 8'hFF);
  endtask

  task automatic t_outside;
    wr(13'h1FE3, 8'h00);
    rd(13'h0FE7);
    check("R9 no oe outside", {8'h0, rdata_oe}, 9'h0);
    wr(13'h0FE0, 8'h00);
    rd_expect("R9 bank kept", 13'h1000, rom_byte(14'h1800));
    wr(13'h1FE9, 8'h00);
    wr(13'h1830, 8'h5E);
    wr(13'h0830, 8'h01);
    wr(13'h0FE8, 8'h00);
    rd_expect("R9 ram and page kept", 13'h1930, 8'h5E);
  endtask

  task automatic t_timing;
    wr(13'h1840, 8'hE1);
    @(negedge clk);
    addr = 13'h1940; rd_en = 1'b1;
    @(negedge clk);
    check("R10 write seen next read", {rdata_oe, rdata}, {1'b1, 8'hE1});
    addr = 13'h1941; rd_en = 1'b1; wr_en = 1'b1; wdata = 8'h22;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R10 no oe on dual strobe", {8'h0, rdata_oe}, 9'h0);
    @(negedge clk);
    check("R10 oe idle", {8'h0, rdata_oe}, 9'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_banks();
    t_fixed();
    t_window_ram();
    t_persist();
    t_pages();
    t_outside();
    t_timing();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule